// File: doc/BRIEF.md
# Paired-Page Translation Buffer

This block translates virtual addresses to physical addresses through a fully associative table. Each slot holds one tag that covers an aligned pair of 4 KB virtual pages and two physical frame numbers, one for the even page of the pair and one for the odd page. Bit 0 of the virtual page number picks which of the two frames is used. One comparator therefore serves two translations, and 48 slots reach as far as 96 single-page slots would. Each half of a slot also carries its own valid bit and its own cache-policy bit, 1 for write-back and 0 for write-through. The policy bit of the selected half comes out with the translation.

The lookup port is a combinational query. A virtual address and an 8-bit address-space tag go in, and a hit, miss or invalid-page indication comes out in the same cycle, with the physical address and the policy bit. The probe port is also combinational. It reports the index of the slot whose tag matches, or that no slot matches. The write port is plain control with no handshake: when the write enable is high at a rising clock edge, the addressed slot is replaced. Neither query port can stall, and neither has back-pressure. A result is valid in the cycle its address is presented, and it is only meaningful while that address is held. If software loads two slots that match the same address, the lowest index wins.

Top module: `tlb_pair_top`

## Requirements
- R1: After reset no slot is active. Every lookup reports a miss and every probe reports not found.
- R2: A write updates the slot at `wr_idx` at the next rising clock edge. A write whose index is 48 or more changes no slot.
- R3: A slot matches when its tag equals virtual-address bits [31:13], its valid bits are not both clear, and either its global bit is set or its stored address-space tag equals the presented one.
- R4: Virtual-address bit 12 selects the frame: 0 selects the even frame and 1 selects the odd frame. On a hit the physical address is {selected frame, va[11:0]}.
- R5: On a hit, `lk_wb` equals the policy bit of the selected half (1 for write-back, 0 for write-through).
- R6: A match whose selected half is invalid raises `lk_inval` and does not raise `lk_hit`. A slot with both halves invalid never matches.
- R7: In every cycle exactly one of `lk_hit`, `lk_miss` and `lk_inval` is high. When `lk_hit` is low, `lk_pa` and `lk_wb` are zero.
- R8: The probe returns `pr_found`=1 and the index of the lowest matching slot, or `pr_found`=0 and index 0 when no slot matches.
- R9: When several slots match a lookup, the translation comes from the lowest-indexed matching slot.
- R10: The lookup and probe results follow their inputs in the same cycle, with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_va | input | 32 | Lookup virtual address |
| lk_asid | input | 8 | Lookup address-space tag |
| lk_hit | output | 1 | Valid translation found |
| lk_miss | output | 1 | No slot matches |
| lk_inval | output | 1 | Slot matches but the selected half is invalid |
| lk_pa | output | 36 | Physical address, zero unless hit |
| lk_wb | output | 1 | Policy of the selected page: 1 for write-back, 0 for write-through |
| pr_va | input | 32 | Probe virtual address |
| pr_asid | input | 8 | Probe address-space tag |
| pr_found | output | 1 | Probe matched a slot |
| pr_idx | output | 6 | Lowest matching slot index |
| wr_en | input | 1 | Write strobe |
| wr_idx | input | 6 | Slot to replace |
| wr_tag | input | 19 | Tag for the page pair (virtual page number bits above bit 0) |
| wr_asid | input | 8 | Address-space tag to store |
| wr_global | input | 1 | Match any address-space tag |
| wr_pfn_even | input | 24 | Even-page frame |
| wr_valid_even | input | 1 | Even half valid |
| wr_wb_even | input | 1 | Even half policy |
| wr_pfn_odd | input | 24 | Odd-page frame |
| wr_valid_odd | input | 1 | Odd half valid |
| wr_wb_odd | input | 1 | Odd half policy |

## Verification
The assertions check four things on every cycle. A write lands in the addressed slot, and an idle cycle or an out-of-range write leaves the table unchanged. The priority encoder always returns the lowest requesting index. The three lookup outcomes are mutually exclusive, and a hit carries the page offset through unchanged. Only the bench's scenarios can show that the right frame and policy come out. They cover even and odd selection, address-space filtering and the global override, invalid halves, duplicate slots, and an ignored out-of-range write. The bench compares every result against a model of the table it keeps itself.

// File: rtl/tlb_pair_pkg.sv
package tlb_pair_pkg;
  parameter int VA_W   = 32;
  parameter int PA_W   = 36;
  parameter int OFS_W  = 12;
  parameter int ASID_W = 8;

  localparam int VPN_W = VA_W - OFS_W;
  localparam int TAG_W = VPN_W - 1;
  localparam int PFN_W = PA_W - OFS_W;

  typedef struct packed {
    logic [PFN_W-1:0] pfn;
    logic             v;
    logic             wb;
  } half_t;

  typedef struct packed {
    logic [TAG_W-1:0]  tag;
    logic [ASID_W-1:0] asid;
    logic              g;
    half_t             ev;
    half_t             od;
  } slot_t;

  localparam int SLOT_W = $bits(slot_t);

  typedef enum logic [1:0] {
    LK_MISS  = 2'd0,
    LK_HIT   = 2'd1,
    LK_INVAL = 2'd2
  } lk_res_e;
endpackage

// File: rtl/tlb_pair_store.sv
module tlb_pair_store
  import tlb_pair_pkg::*;
#(
  parameter int N     = 48,
  parameter int IDX_W = $clog2(N)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  slot_t            wr_slot,
  output slot_t            slots [N]
);
  logic [N*SLOT_W-1:0] flat;

  for (genvar i = 0; i < N; i++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        slots[i] <= '0;
      else if (wr_en && (wr_idx == IDX_W'(i)))
        slots[i] <= wr_slot;
    end
    assign flat[i*SLOT_W +: SLOT_W] = slots[i];
  end

  assert_write_lands_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (int'(wr_idx) < N)) |=> (slots[$past(wr_idx)] == $past(wr_slot)));

  assert_idle_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en || (int'(wr_idx) >= N)) |=> $stable(flat));
endmodule

// File: rtl/tlb_pair_match.sv
module tlb_pair_match
  import tlb_pair_pkg::*;
#(
  parameter int N = 48
) (
  input  slot_t             slots [N],
  input  logic [TAG_W-1:0]  tag,
  input  logic [ASID_W-1:0] asid,
  output logic [N-1:0]      hit_vec
);
  for (genvar i = 0; i < N; i++) begin : g_cmp
    logic active, tag_eq, space_ok;
    assign active   = slots[i].ev.v | slots[i].od.v;
    assign tag_eq   = (slots[i].tag == tag);
    assign space_ok = slots[i].g | (slots[i].asid == asid);
    assign hit_vec[i] = active & tag_eq & space_ok;
  end
endmodule

// File: rtl/tlb_pair_prio.sv
module tlb_pair_prio #(
  parameter int N     = 48,
  parameter int IDX_W = $clog2(N)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N-1:0]     req,
  output logic             found,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        found = 1'b1;
        idx   = IDX_W'(i);
      end
    end
  end

  logic [N-1:0] below_mask;
  always_comb begin
    below_mask = '0;
    for (int i = 0; i < N; i++)
      below_mask[i] = (IDX_W'(i) < idx);
  end

  assert_lowest_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    found |-> (req[idx] && ((req & below_mask) == '0)));

  assert_none_found_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !found |-> (req == '0 && idx == '0));
endmodule

// File: rtl/tlb_pair_top.sv
module tlb_pair_top
  import tlb_pair_pkg::*;
#(
  parameter int N     = 48,
  parameter int IDX_W = $clog2(N)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [VA_W-1:0]   lk_va,
  input  logic [ASID_W-1:0] lk_asid,
  output logic              lk_hit,
  output logic              lk_miss,
  output logic              lk_inval,
  output logic [PA_W-1:0]   lk_pa,
  output logic              lk_wb,
  input  logic [VA_W-1:0]   pr_va,
  input  logic [ASID_W-1:0] pr_asid,
  output logic              pr_found,
  output logic [IDX_W-1:0]  pr_idx,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic [ASID_W-1:0] wr_asid,
  input  logic              wr_global,
  input  logic [PFN_W-1:0]  wr_pfn_even,
  input  logic              wr_valid_even,
  input  logic              wr_wb_even,
  input  logic [PFN_W-1:0]  wr_pfn_odd,
  input  logic              wr_valid_odd,
  input  logic              wr_wb_odd
);
  localparam int SEL_BIT = OFS_W;

  slot_t slots [N];
  slot_t wr_slot;

  always_comb begin
    wr_slot.tag   = wr_tag;
    wr_slot.asid  = wr_asid;
    wr_slot.g     = wr_global;
    wr_slot.ev.pfn = wr_pfn_even;
    wr_slot.ev.v   = wr_valid_even;
    wr_slot.ev.wb  = wr_wb_even;
    wr_slot.od.pfn = wr_pfn_odd;
    wr_slot.od.v   = wr_valid_odd;
    wr_slot.od.wb  = wr_wb_odd;
  end

  tlb_pair_store #(.N(N), .IDX_W(IDX_W)) u_store (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_slot(wr_slot), .slots(slots)
  );

  // Lookup path and probe path share the comparator and encoder design.
  logic [N-1:0]     lk_vec, pr_vec;
  logic             lk_found;
  logic [IDX_W-1:0] lk_idx;

  tlb_pair_match #(.N(N)) u_lk_match (
    .slots(slots), .tag(lk_va[VA_W-1:SEL_BIT+1]), .asid(lk_asid), .hit_vec(lk_vec)
  );
  tlb_pair_match #(.N(N)) u_pr_match (
    .slots(slots), .tag(pr_va[VA_W-1:SEL_BIT+1]), .asid(pr_asid), .hit_vec(pr_vec)
  );

  tlb_pair_prio #(.N(N), .IDX_W(IDX_W)) u_lk_prio (
    .clk(clk), .rst_n(rst_n), .req(lk_vec), .found(lk_found), .idx(lk_idx)
  );
  tlb_pair_prio #(.N(N), .IDX_W(IDX_W)) u_pr_prio (
    .clk(clk), .rst_n(rst_n), .req(pr_vec), .found(pr_found), .idx(pr_idx)
  );

  slot_t   sel_slot;
  half_t   sel_half;
  lk_res_e res;

  always_comb begin
    sel_slot = '0;
    for (int i = 0; i < N; i++)
      if (lk_found && (lk_idx == IDX_W'(i))) sel_slot = slots[i];
    sel_half = lk_va[SEL_BIT] ? sel_slot.od : sel_slot.ev;
    if (!lk_found)       res = LK_MISS;
    else if (sel_half.v) res = LK_HIT;
    else                 res = LK_INVAL;
  end

  assign lk_hit   = (res == LK_HIT);
  assign lk_miss  = (res == LK_MISS);
  assign lk_inval = (res == LK_INVAL);
  assign lk_pa    = lk_hit ? {sel_half.pfn, lk_va[OFS_W-1:0]} : '0;
  assign lk_wb    = lk_hit & sel_half.wb;

  assert_one_outcome_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot({lk_hit, lk_miss, lk_inval}));

  assert_quiet_on_nohit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_hit |-> (lk_pa == '0 && !lk_wb));

  assert_offset_passes_R4: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> (lk_pa[OFS_W-1:0] == lk_va[OFS_W-1:0]));

  assert_probe_agrees_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((pr_va[VA_W-1:SEL_BIT+1] == lk_va[VA_W-1:SEL_BIT+1]) && (pr_asid == lk_asid))
      |-> (pr_found == !lk_miss));
endmodule

// File: tb/tlb_pair_top_tb_top.sv
module tlb_pair_top_tb_top;
  import tlb_pair_pkg::*;
  localparam int N = 48;
  localparam int IW = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  always #10 clk = ~clk;

  logic [VA_W-1:0] lk_va = '0, pr_va = '0;
  logic [ASID_W-1:0] lk_asid = '0, pr_asid = '0, wr_asid = '0;
  logic lk_hit, lk_miss, lk_inval, lk_wb, pr_found;
  logic [PA_W-1:0] lk_pa;
  logic [IW-1:0] pr_idx, wr_idx = '0;
  logic wr_en = 0, wr_global = 0, wr_valid_even = 0, wr_wb_even = 0, wr_valid_odd = 0, wr_wb_odd = 0;
  logic [TAG_W-1:0] wr_tag = '0;
  logic [PFN_W-1:0] wr_pfn_even = '0, wr_pfn_odd = '0;

  tlb_pair_top dut_i (.*);

  // bench model of the table
  logic [TAG_W-1:0]  m_tag  [N];
  logic [ASID_W-1:0] m_asid [N];
  logic              m_g    [N];
  logic [PFN_W-1:0]  m_pe [N], m_po [N];
  logic              m_ve [N], m_vo [N], m_we [N], m_wo [N];

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int find(input logic [VA_W-1:0] va, input logic [ASID_W-1:0] asid);
    for (int i = 0; i < N; i++)
      if ((m_ve[i] || m_vo[i]) && m_tag[i] == va[VA_W-1:OFS_W+1] && (m_g[i] || m_asid[i] == asid))
        return i;
    return -1;
  endfunction

  task automatic wr(input int idx, input logic [TAG_W-1:0] tag, input logic [ASID_W-1:0] asid,
                    input bit g, input logic [PFN_W-1:0] pe, input bit ve, input bit we,
                    input logic [PFN_W-1:0] po, input bit vo, input bit wo);
    wr_en = 1; wr_idx = IW'(idx); wr_tag = tag; wr_asid = asid; wr_global = g;
    wr_pfn_even = pe; wr_valid_even = ve; wr_wb_even = we;
    wr_pfn_odd = po; wr_valid_odd = vo; wr_wb_odd = wo;
    @(posedge clk);
    if (idx < N) begin
      m_tag[idx] = tag; m_asid[idx] = asid; m_g[idx] = g;
      m_pe[idx] = pe; m_ve[idx] = ve; m_we[idx] = we;
      m_po[idx] = po; m_vo[idx] = vo; m_wo[idx] = wo;
    end
    @(negedge clk);
    wr_en = 0;
  endtask

  // Lookup and probe checked in the same cycle the address is driven (R10).
  task automatic look(input logic [VA_W-1:0] va, input logic [ASID_W-1:0] asid, input string req);
    int k;
    bit odd, v, w;
    logic [PFN_W-1:0] f;
    logic [PA_W-1:0] epa;
    lk_va = va; lk_asid = asid; pr_va = va; pr_asid = asid;
    #2;
    k = find(va, asid);
    odd = va[OFS_W];
    if (k < 0) begin
      chk(lk_miss && !lk_hit && !lk_inval && lk_pa == '0 && !lk_wb, {req, " miss"},
          {lk_hit, lk_miss, lk_inval}, 3'b010);
      chk(!pr_found && pr_idx == '0, {req, " probe none R8"}, {pr_found, pr_idx}, 0);
    end else begin
      v = odd ? m_vo[k] : m_ve[k];
      w = odd ? m_wo[k] : m_we[k];
      f = odd ? m_po[k] : m_pe[k];
      epa = {f, va[OFS_W-1:0]};
      chk(pr_found && int'(pr_idx) == k, {req, " probe R8"}, {pr_found, pr_idx}, {1'b1, IW'(k)});
      if (v) begin
        chk(lk_hit && !lk_miss && !lk_inval, {req, " hit R7"}, {lk_hit, lk_miss, lk_inval}, 3'b100);
        chk(lk_pa == epa, {req, " pa R4"}, lk_pa, epa);
        chk(lk_wb == w, {req, " policy R5"}, lk_wb, w);
      end else
        chk(lk_inval && !lk_hit && !lk_miss && lk_pa == '0, {req, " inval R6"},
            {lk_hit, lk_miss, lk_inval}, 3'b001);
    end
  endtask

  function automatic logic [VA_W-1:0] mkva(input logic [TAG_W-1:0] tag, input bit odd,
                                           input logic [OFS_W-1:0] ofs);
    return {tag, odd, ofs};
  endfunction

  initial begin
    for (int i = 0; i < N; i++) begin
      m_tag[i] = '0; m_asid[i] = '0; m_g[i] = 0; m_pe[i] = '0; m_po[i] = '0;
      m_ve[i] = 0; m_vo[i] = 0; m_we[i] = 0; m_wo[i] = 0;
    end
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1: empty after reset
    look(mkva(19'h0, 0, 12'h000), 8'h00, "R1 reset va0");
    look(mkva(19'h123, 1, 12'h456), 8'h07, "R1 reset other");

    // R4/R5/R6: even valid write-back, odd invalid
    wr(5, 19'h123, 8'h07, 0, 24'hABCDEF, 1, 1, 24'h111111, 0, 0);
    look(mkva(19'h123, 0, 12'h9A5), 8'h07, "R4 even page");
    look(mkva(19'h123, 1, 12'h9A5), 8'h07, "R6 odd invalid");
    // R3: other address space misses
    look(mkva(19'h123, 0, 12'h001), 8'h08, "R3 asid mismatch");

    // R3/R5: global, odd write-through, even write-back
    wr(6, 19'h200, 8'h01, 1, 24'h000A00, 1, 1, 24'h000B00, 1, 0);
    look(mkva(19'h200, 1, 12'hFFF), 8'hEE, "R3 global odd");
    look(mkva(19'h200, 0, 12'h000), 8'h33, "R5 global even");

    // R6: both halves invalid never matches
    wr(7, 19'h300, 8'h00, 1, 24'h5, 0, 0, 24'h6, 0, 0);
    look(mkva(19'h300, 0, 12'h010), 8'h00, "R6 dead slot");

    // R8/R9: duplicate tags, lowest index wins
    wr(10, 19'h444, 8'h02, 0, 24'hD10, 1, 0, 24'hD11, 1, 1);
    wr(3,  19'h444, 8'h02, 0, 24'hD30, 1, 1, 24'hD31, 1, 0);
    look(mkva(19'h444, 1, 12'h123), 8'h02, "R9 duplicate");

    // R2: out-of-range write ignored, in-range replacement takes effect
    wr(50, 19'h3FF, 8'h00, 1, 24'hEEE, 1, 1, 24'hEEE, 1, 1);
    look(mkva(19'h3FF, 0, 12'h000), 8'h00, "R2 out of range");
    wr(5, 19'h555, 8'h07, 0, 24'h55, 1, 0, 24'h56, 1, 1);
    look(mkva(19'h123, 0, 12'h000), 8'h07, "R2 replaced old");
    look(mkva(19'h555, 1, 12'h777), 8'h07, "R2 replaced new");
    look(mkva(19'h0, 0, 12'h0), 8'h00, "R10 back to miss");

    // Constrained random mix
    for (int it = 0; it < 400; it++) begin
      if ($urandom_range(0, 2) == 0)
        wr($urandom_range(0, 55), TAG_W'($urandom_range(0, 15)), ASID_W'($urandom_range(0, 3)),
           $urandom_range(0, 3) == 0, PFN_W'($urandom), $urandom_range(0, 3) != 0, 1'($urandom),
           PFN_W'($urandom), $urandom_range(0, 3) != 0, 1'($urandom));
      else begin
        look(mkva(TAG_W'($urandom_range(0, 15)), 1'($urandom), OFS_W'($urandom)),
             ASID_W'($urandom_range(0, 3)), "R3 random");
        @(negedge clk);
      end
    end
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog R1 actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule